// File: doc/BRIEF.md
# Maskable Interrupt Controller with Vectoring

This block gathers interrupt requests from three kinds of origin: a set of maskable hardware sources, eight nonmaskable exception lines, and a software interrupt request that carries its own 8-bit type. Each request is latched into a pending bit. One pending request is chosen and presented to the processor core as an interrupt request with its 8-bit type and the byte address of its entry in a 1 KB vector table at address zero. The core pulses an acknowledge input to retire the presented request.

Maskable source `i` owns type `8 + i`. With the default of 13 sources, these are types 0x08 to 0x14. A maskable source is presented only when the global enable input is 1 and its own mask bit is 0. The mask bits have two views onto one register. The first is a per-source control port that writes or reads a single bit chosen by an index. The second is an aggregate port that writes or reads all bits at once. Both kinds of write land on the same clock edge, so the selection logic never sees a partly updated mask. Exceptions and software interrupts ignore both the enable flag and the mask bits. The outputs are decoded combinationally from registered state, so a mask change governs the request output from the cycle after the write edge.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1 (`agg_rdata` = all ones), no request is pending, and `irq` is 0.
- R2: A pulse on `src_req[i]` makes source `i` pending. When `gie` is 1 and its mask bit is 0, `irq` is 1 from the next cycle, with `irq_type` = 8 + i and `irq_vaddr` = `irq_type` × 4. `irq_vaddr` is 20 bits wide and its bits 19:10 are zero.
- R3: While `gie` is 0, no maskable source is presented. Its pending bit is kept, and the source is presented once `gie` returns to 1.
- R4: A source whose mask bit is 1 is never presented, whatever the value of `gie`. Its pending bit is kept.
- R5: When `ctl_we` is 1 and `ctl_sel` < NUM_SRC, the next edge writes `ctl_wmask` into that source's mask bit and leaves the other bits unchanged. `ctl_rmask` shows the mask bit selected by `ctl_sel`.
- R6: When `agg_we` is 1, the next edge replaces all mask bits with `agg_wdata`. Bit `i` of `agg_rdata` is the same bit that `ctl_rmask` shows for `ctl_sel` = i. If both writes occur in the same cycle, the per-source write decides its own bit.
- R7: A pulse on `exc_req[k]` presents type k (0 to 7) from the next cycle. This happens regardless of `gie` and of any mask bit.
- R8: A pulse on `swi_req` latches `swi_type` and presents that type from the next cycle. Any of the 256 types may be used, and neither `gie` nor the mask bits apply.
- R9: Among the presentable requests, the lowest type is presented. On equal types, an exception comes first, then the software request, then a maskable source.
- R10: An `ack` pulse while `irq` is 1 clears only the presented request's pending bit. An `ack` while `irq` is 0 changes nothing. A new request arriving in the same cycle as its own clear wins over the clear.
- R11: A per-source write with `ctl_sel` ≥ NUM_SRC changes no mask bit, and `ctl_rmask` reads 0 for such an index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Request pulses from maskable sources |
| exc_req | input | 8 | Nonmaskable exception request pulses, types 0 to 7 |
| swi_req | input | 1 | Software interrupt request pulse |
| swi_type | input | 8 | Type carried by the software request |
| gie | input | 1 | Global enable for maskable sources |
| ctl_we | input | 1 | Per-source mask write strobe |
| ctl_sel | input | SEL_W | Index of the source addressed by the per-source port |
| ctl_wmask | input | 1 | Mask value to write |
| ctl_rmask | output | 1 | Mask bit of the addressed source |
| agg_we | input | 1 | Aggregate mask write strobe |
| agg_wdata | input | NUM_SRC | New value for all mask bits |
| agg_rdata | output | NUM_SRC | Current value of all mask bits |
| ack | input | 1 | Acknowledge pulse from the core |
| irq | output | 1 | A request is being presented |
| irq_type | output | 8 | Type of the presented request |
| irq_vaddr | output | 20 | Vector table byte address of the presented request |

## Verification
The assertions assume that `ack` is pulsed only for the request being presented. They also assume that a source does not re-raise its request in the same cycle its pending bit is cleared, since the clear check excludes that cycle. The stimulus follows these assumptions. Every acknowledge comes after the bench has observed the presented type, and every request is a single-cycle pulse that never overlaps an acknowledge of the same source. No new software request is issued while an earlier one is still pending.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int TYPE_W   = 8;
    localparam int VADDR_W  = 20;
    localparam int NUM_EXC  = 8;
    localparam int MSK_BASE = 8;

    typedef logic [TYPE_W-1:0] irq_type_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXC  = 2'd1,
        SRC_SWI  = 2'd2,
        SRC_MSK  = 2'd3
    } src_kind_e;

    typedef struct packed {
        logic      valid;
        src_kind_e kind;
        irq_type_t itype;
    } pick_t;

    // Vector entries are four bytes wide in a table based at zero.
    function automatic logic [VADDR_W-1:0] vec_addr(input irq_type_t t);
        return {{(VADDR_W-TYPE_W-2){1'b0}}, t, 2'b00};
    endfunction

endpackage

// File: rtl/ivc_mask_bank.sv
module ivc_mask_bank #(
    parameter int NUM_SRC = 13,
    parameter int SEL_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_we,
    input  logic [SEL_W-1:0]   ctl_sel,
    input  logic               ctl_wmask,
    input  logic               agg_we,
    input  logic [NUM_SRC-1:0] agg_wdata,
    output logic [NUM_SRC-1:0] mask_q,
    output logic               ctl_rmask
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_SRC - 1);

    logic               sel_ok;
    logic [NUM_SRC-1:0] mask_d;

    assign sel_ok = (ctl_sel <= LAST_SEL);

    // Both views resolve into one next-state vector; a single edge commits it.
    always_comb begin
        mask_d = mask_q;
        if (agg_we)
            mask_d = agg_wdata;
        if (ctl_we && sel_ok)
            mask_d[ctl_sel] = ctl_wmask;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '1;
        else     mask_q <= mask_d;
    end

    assign ctl_rmask = sel_ok ? mask_q[ctl_sel] : 1'b0;

    p_reset_masks_r1: assert property (@(posedge clk)
        rst |=> (&mask_q));

    p_single_write_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && sel_ok) |=> (mask_q[$past(ctl_sel)] == $past(ctl_wmask)));

    p_agg_write_r6: assert property (@(posedge clk) disable iff (rst)
        (agg_we && !ctl_we) |=> (mask_q == $past(agg_wdata)));

    p_bad_sel_r11: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && !sel_ok && !agg_we) |=> $stable(mask_q));

endmodule

// File: rtl/ivc_pending.sv
module ivc_pending
    import ivc_pkg::*;
#(
    parameter int NUM_SRC = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_EXC-1:0] exc_req,
    input  logic               swi_req,
    input  irq_type_t          swi_type,
    input  logic               ack,
    input  pick_t              pick,
    output logic [NUM_SRC-1:0] msk_pend,
    output logic [NUM_EXC-1:0] exc_pend,
    output logic               swi_pend,
    output irq_type_t          swi_type_q
);
    logic               do_clr;
    logic [NUM_SRC-1:0] msk_clr;
    logic [NUM_EXC-1:0] exc_clr;
    logic               swi_clr;

    assign do_clr  = ack && pick.valid;
    assign swi_clr = do_clr && (pick.kind == SRC_SWI);

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            msk_clr[i] = do_clr && (pick.kind == SRC_MSK) &&
                         (pick.itype == irq_type_t'(MSK_BASE + i));
        for (int k = 0; k < NUM_EXC; k++)
            exc_clr[k] = do_clr && (pick.kind == SRC_EXC) &&
                         (pick.itype == irq_type_t'(k));
    end

    // A fresh request outranks the clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            msk_pend   <= '0;
            exc_pend   <= '0;
            swi_pend   <= 1'b0;
            swi_type_q <= '0;
        end else begin
            msk_pend <= (msk_pend & ~msk_clr) | src_req;
            exc_pend <= (exc_pend & ~exc_clr) | exc_req;
            if (swi_req) begin
                swi_pend   <= 1'b1;
                swi_type_q <= swi_type;
            end else if (swi_clr) begin
                swi_pend   <= 1'b0;
            end
        end
    end

    p_reset_pend_r1: assert property (@(posedge clk)
        rst |=> (msk_pend == '0 && exc_pend == '0 && !swi_pend));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr_chk
        p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
            (msk_clr[g] && !src_req[g]) |=> !msk_pend[g]);
    end

    p_idle_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (ack && !pick.valid && src_req == '0 && exc_req == '0 && !swi_req)
        |=> ($stable(msk_pend) && $stable(exc_pend) && $stable(swi_pend)));

endmodule

// File: rtl/ivc_select.sv
module ivc_select
    import ivc_pkg::*;
#(
    parameter int NUM_SRC = 13
) (
    input  logic [NUM_SRC-1:0] msk_pend,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic               gie,
    input  logic [NUM_EXC-1:0] exc_pend,
    input  logic               swi_pend,
    input  irq_type_t          swi_type_q,
    output pick_t              pick
);
    logic [NUM_SRC-1:0] cand;
    logic               m_ok, e_ok;
    irq_type_t          m_type, e_type;

    assign cand = msk_pend & ~mask_q & {NUM_SRC{gie}};

    always_comb begin
        m_ok   = 1'b0;
        m_type = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                m_ok   = 1'b1;
                m_type = irq_type_t'(MSK_BASE + i);
            end
        end
        e_ok   = 1'b0;
        e_type = '0;
        for (int k = NUM_EXC - 1; k >= 0; k--) begin
            if (exc_pend[k]) begin
                e_ok   = 1'b1;
                e_type = irq_type_t'(k);
            end
        end
    end

    // Lowest type wins; later stages take ties, giving exception > software > source.
    always_comb begin
        pick = '{valid: 1'b0, kind: SRC_NONE, itype: '0};
        if (m_ok)
            pick = '{valid: 1'b1, kind: SRC_MSK, itype: m_type};
        if (swi_pend && (!pick.valid || swi_type_q <= pick.itype))
            pick = '{valid: 1'b1, kind: SRC_SWI, itype: swi_type_q};
        if (e_ok && (!pick.valid || e_type <= pick.itype))
            pick = '{valid: 1'b1, kind: SRC_EXC, itype: e_type};
    end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import ivc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int SEL_W   = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_req,
    input  logic [7:0]           exc_req,
    input  logic                 swi_req,
    input  logic [7:0]           swi_type,
    input  logic                 gie,
    input  logic                 ctl_we,
    input  logic [SEL_W-1:0]     ctl_sel,
    input  logic                 ctl_wmask,
    output logic                 ctl_rmask,
    input  logic                 agg_we,
    input  logic [NUM_SRC-1:0]   agg_wdata,
    output logic [NUM_SRC-1:0]   agg_rdata,
    input  logic                 ack,
    output logic                 irq,
    output logic [7:0]           irq_type,
    output logic [19:0]          irq_vaddr
);
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] msk_pend;
    logic [NUM_EXC-1:0] exc_pend;
    logic               swi_pend;
    irq_type_t          swi_type_q;
    pick_t              pick;

    ivc_mask_bank #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mask (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_sel   (ctl_sel),
        .ctl_wmask (ctl_wmask),
        .agg_we    (agg_we),
        .agg_wdata (agg_wdata),
        .mask_q    (mask_q),
        .ctl_rmask (ctl_rmask)
    );

    ivc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .src_req    (src_req),
        .exc_req    (exc_req),
        .swi_req    (swi_req),
        .swi_type   (swi_type),
        .ack        (ack),
        .pick       (pick),
        .msk_pend   (msk_pend),
        .exc_pend   (exc_pend),
        .swi_pend   (swi_pend),
        .swi_type_q (swi_type_q)
    );

    ivc_select #(.NUM_SRC(NUM_SRC)) u_sel (
        .msk_pend   (msk_pend),
        .mask_q     (mask_q),
        .gie        (gie),
        .exc_pend   (exc_pend),
        .swi_pend   (swi_pend),
        .swi_type_q (swi_type_q),
        .pick       (pick)
    );

    assign agg_rdata = mask_q;
    assign irq       = pick.valid;
    assign irq_type  = pick.itype;
    assign irq_vaddr = vec_addr(pick.itype);

    p_masked_blocked_r4: assert property (@(posedge clk) disable iff (rst)
        (irq && pick.kind == SRC_MSK) |->
        !mask_q[irq_type - 8'(MSK_BASE)]);

    p_gie_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (irq && !gie) |-> (pick.kind != SRC_MSK));

    p_exc_bypass_r7: assert property (@(posedge clk) disable iff (rst)
        (exc_pend != '0) |-> (irq && irq_type < 8'(NUM_EXC)));

    p_vaddr_range_r2: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_vaddr[1:0] == 2'b00 && irq_vaddr[19:10] == '0));

    p_swi_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        swi_pend |-> irq);

endmodule

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
    localparam int N  = 13;
    localparam int SW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src_req = '0;
    logic [7:0]    exc_req = '0;
    logic          swi_req = 1'b0;
    logic [7:0]    swi_type = '0;
    logic          gie = 1'b0;
    logic          ctl_we = 1'b0;
    logic [SW-1:0] ctl_sel = '0;
    logic          ctl_wmask = 1'b0;
    logic          ctl_rmask;
    logic          agg_we = 1'b0;
    logic [N-1:0]  agg_wdata = '0;
    logic [N-1:0]  agg_rdata;
    logic          ack = 1'b0;
    logic          irq;
    logic [7:0]    irq_type;
    logic [19:0]   irq_vaddr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_vec_ctrl #(.NUM_SRC(N)) uut (
        .clk(clk), .rst(rst), .src_req(src_req), .exc_req(exc_req),
        .swi_req(swi_req), .swi_type(swi_type), .gie(gie),
        .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wmask(ctl_wmask),
        .ctl_rmask(ctl_rmask), .agg_we(agg_we), .agg_wdata(agg_wdata),
        .agg_rdata(agg_rdata), .ack(ack), .irq(irq), .irq_type(irq_type),
        .irq_vaddr(irq_vaddr)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_irq(string req, logic [7:0] t);
        chk(req, {31'd0, irq}, 32'd1);
        chk(req, {24'd0, irq_type}, {24'd0, t});
        chk(req, {12'd0, irq_vaddr}, {22'd0, t, 2'b00});
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic agg_write(logic [N-1:0] v);
        agg_we = 1'b1; agg_wdata = v; tick(); agg_we = 1'b0;
    endtask

    task automatic ctl_write(logic [SW-1:0] s, logic m);
        ctl_we = 1'b1; ctl_sel = s; ctl_wmask = m; tick(); ctl_we = 1'b0;
    endtask

    task automatic raise_src(int i);
        src_req[i] = 1'b1; tick(); src_req = '0;
    endtask

    task automatic t_reset();
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 agg_rdata", {19'd0, agg_rdata}, 32'h1FFF);
        ctl_sel = 4'd0; #1;
        chk("R1 ctl_rmask", {31'd0, ctl_rmask}, 32'd1);
    endtask

    task automatic t_basic();
        agg_write('0);
        gie = 1'b1;
        raise_src(2);
        expect_irq("R2 src2", 8'h0A);
        do_ack();
        chk("R10 cleared", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_gie();
        gie = 1'b0;
        raise_src(0);
        chk("R3 gie low", {31'd0, irq}, 32'd0);
        gie = 1'b1; #1;
        expect_irq("R3 gie back", 8'h08);
        do_ack();
    endtask

    task automatic t_mask();
        ctl_write(4'd5, 1'b1);
        ctl_sel = 4'd5; #1;
        chk("R5 rmask", {31'd0, ctl_rmask}, 32'd1);
        chk("R6 shared view", {19'd0, agg_rdata}, 32'h0020);
        raise_src(5);
        chk("R4 masked", {31'd0, irq}, 32'd0);
        ctl_write(4'd5, 1'b0);
        expect_irq("R5 unmask", 8'h0D);
        do_ack();
    endtask

    task automatic t_agg();
        agg_we = 1'b1; agg_wdata = '1;
        ctl_we = 1'b1; ctl_sel = 4'd3; ctl_wmask = 1'b0;
        tick();
        agg_we = 1'b0; ctl_we = 1'b0;
        chk("R6 both writes", {19'd0, agg_rdata}, 32'h1FF7);
        src_req[3] = 1'b1; src_req[4] = 1'b1; tick(); src_req = '0;
        expect_irq("R4 only src3", 8'h0B);
        do_ack();
        chk("R4 src4 held", {31'd0, irq}, 32'd0);
        agg_write('0);
        expect_irq("R6 agg unmask", 8'h0C);
        do_ack();
    endtask

    task automatic t_exc();
        agg_write('1);
        gie = 1'b0;
        exc_req[6] = 1'b1; tick(); exc_req = '0;
        expect_irq("R7 exc6", 8'h06);
        do_ack();
        chk("R7 cleared", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_swi();
        swi_req = 1'b1; swi_type = 8'h80; tick(); swi_req = 1'b0;
        expect_irq("R8 swi80", 8'h80);
        do_ack();
        swi_req = 1'b1; swi_type = 8'hFF; tick(); swi_req = 1'b0;
        expect_irq("R8 swiFF", 8'hFF);
        do_ack();
        chk("R8 cleared", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_prio();
        agg_write('0);
        gie = 1'b1;
        src_req[1] = 1'b1; swi_req = 1'b1; swi_type = 8'h20; exc_req[4] = 1'b1;
        tick();
        src_req = '0; swi_req = 1'b0; exc_req = '0;
        expect_irq("R9 exc first", 8'h04);
        do_ack();
        expect_irq("R9 src next", 8'h09);
        do_ack();
        expect_irq("R9 swi last", 8'h20);
        do_ack();
        chk("R9 drained", {31'd0, irq}, 32'd0);
        src_req[2] = 1'b1; swi_req = 1'b1; swi_type = 8'h0A; tick();
        src_req = '0; swi_req = 1'b0;
        expect_irq("R9 tie first", 8'h0A);
        do_ack();
        expect_irq("R9 tie second", 8'h0A);
        do_ack();
        chk("R9 tie drained", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_bad_sel();
        agg_write('1);
        ctl_write(4'd15, 1'b0);
        chk("R11 no change", {19'd0, agg_rdata}, 32'h1FFF);
        ctl_sel = 4'd15; #1;
        chk("R11 read zero", {31'd0, ctl_rmask}, 32'd0);
    endtask

    task automatic t_idle_ack();
        raise_src(7);
        chk("R10 masked idle", {31'd0, irq}, 32'd0);
        do_ack();
        ctl_write(4'd7, 1'b0);
        expect_irq("R10 pending kept", 8'h0F);
        do_ack();
        chk("R10 final", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_basic();
        t_gie();
        t_mask();
        t_agg();
        t_exc();
        t_swi();
        t_prio();
        t_bad_sel();
        t_idle_ack();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule